// File: doc/BRIEF.md
# Dual Wiper Register Two-Wire Slave

This block is the serial control front end of a dual 256-step digital potentiometer. It watches an open-drain two-wire bus (clock SCL and data SDA), both sampled by a much faster system clock. It recognises bus start and stop conditions and answers only to its own 7-bit device address. Two 8-bit volatile wiper registers are held here and drive the resistor network, which lies outside this block.

The device address is fixed at build time or partly set by pins. A parameter picks the variant. In fixed mode all seven bits must equal `0101111`. In pin mode the upper five bits must equal `01011` and the low two bits come from the `addr_pin_i` inputs. A write consists of an address byte, an instruction byte whose top bit names the wiper, and a data byte that is loaded into that wiper. A read streams out the wiper that the most recent instruction byte selected, one byte after another, for as long as the master acknowledges.

There is no stream interface. The wiper values are plain level outputs, and SDA is driven only through a pull-down enable.

Top module: `dual_wiper_i2c`

## Requirements
- R1: After reset both wiper outputs hold their reset values (0x80 by default), the read selection is wiper A, and `sda_pull_o` is 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Before the first START and after a STOP the block never pulls SDA, whatever bits are clocked.
- R3: With `ADDR_MODE`=0 the block acknowledges only the address 0101111, sent MSB first and followed by the read/write bit (1 = read, 0 = write). Any other address is ignored, and neither wiper changes.
- R4: With `ADDR_MODE`=1 the block acknowledges only an address whose upper five bits are 01011 and whose low two bits equal `addr_pin_i[1:0]`.
- R5: On an accepted address, and after each instruction or data byte of an accepted write, `sda_pull_o` is 1 during the ninth SCL clock. It is released after that clock's falling edge.
- R6: Bit 7 of the instruction byte picks the target (0 = wiper A, 1 = wiper B), and its other bits have no effect. The data byte is loaded into the chosen wiper when its acknowledge clock ends.
- R7: A read sends the selected wiper MSB first and then releases SDA for the master's acknowledge bit. On acknowledge (SDA low) another byte follows. On no acknowledge SDA stays released until the next START.
- R8: A read returns the wiper named by the most recent completed instruction byte, which is wiper A after reset.
- R9: A START or STOP that arrives inside a byte aborts the transfer and leaves both wipers unchanged.
- R10: A START arriving in any state, without a preceding STOP, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_pin_i | input | 2 | Address pins that form the low address bits in pin mode |
| sda_pull_o | output | 1 | 1 = drive SDA low |
| wiper_a_o | output | 8 | Wiper A register |
| wiper_b_o | output | 8 | Wiper B register |

## Verification
Two instances share one modelled open-drain bus: one in fixed-address mode and one in pin mode with a different reset value on wiper B. Each acknowledge can therefore be tied to the right device, and a read after reset shows which wiper is selected. The tests cover the following cases:
- bytes clocked before any START
- well-formed writes to each wiper, including an instruction byte with the low bits set
- a foreign address
- two-byte reads that end in acknowledge and then no acknowledge
- bytes cut short by a STOP or by a repeated START

Together these separate address decoding, wiper selection, load timing and abort handling. The reference model checks the wiper values on every clock while SCL is high.

// File: rtl/dwi_pkg.sv
package dwi_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int STRAP_W = 2;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_INSTR,
    S_INSTR_ACK,
    S_DATA,
    S_DATA_ACK,
    S_TX,
    S_TX_ACK
  } bus_st_e;
endpackage

// File: rtl/dwi_line_sync.sv
module dwi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '1;
        else        chain_q <= line_i;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], line_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain_q[STAGES-1];

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~last_q;
  assign fall_o  = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/dwi_addr_match.sv
module dwi_addr_match import dwi_pkg::*; #(
  parameter int                ADDR_MODE = 0,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h2F
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [STRAP_W-1:0] pin_i,
  output logic               hit_o
);
  localparam logic [ADDR_W-1:0] PIN_MASK =
    (ADDR_MODE != 0) ? ADDR_W'((1 << STRAP_W) - 1) : '0;

  logic [ADDR_W-1:0] want;
  assign want  = (BASE_ADDR & ~PIN_MASK) | (ADDR_W'(pin_i) & PIN_MASK);
  assign hit_o = (addr_i == want);
endmodule

// File: rtl/dwi_wiper_bank.sv
module dwi_wiper_bank import dwi_pkg::*; #(
  parameter logic [BYTE_W-1:0] RESET_A = 8'h80,
  parameter logic [BYTE_W-1:0] RESET_B = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] wiper_a_o,
  output logic [BYTE_W-1:0] wiper_b_o
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wiper_a_o <= RESET_A;
      wiper_b_o <= RESET_B;
    end else if (we_i) begin
      if (sel_i) wiper_b_o <= data_i;
      else       wiper_a_o <= data_i;
    end
endmodule

// File: rtl/dual_wiper_i2c.sv
module dual_wiper_i2c import dwi_pkg::*; #(
  parameter int                ADDR_MODE   = 0,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 7'h2F,
  parameter logic [BYTE_W-1:0] RESET_A     = 8'h80,
  parameter logic [BYTE_W-1:0] RESET_B     = 8'h80,
  parameter int                SYNC_STAGES = 2,
  parameter int                SEL_BIT     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [STRAP_W-1:0] addr_pin_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] wiper_a_o,
  output logic [BYTE_W-1:0] wiper_b_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_det, stop_det, addr_hit, wr_en;

  bus_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, rd_byte;
  logic              rw_q, sel_q, sel_nx_q, mack_q, pull_q;

  dwi_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  dwi_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  assign start_det = scl_lvl & sda_fall;
  assign stop_det  = scl_lvl & sda_rise;

  dwi_addr_match #(.ADDR_MODE(ADDR_MODE), .BASE_ADDR(BASE_ADDR)) u_match (
    .addr_i(sh_q[BYTE_W-1:1]), .pin_i(addr_pin_i), .hit_o(addr_hit));

  assign wr_en = (st_q == S_DATA_ACK) && scl_fall && !start_det && !stop_det;

  dwi_wiper_bank #(.RESET_A(RESET_A), .RESET_B(RESET_B)) u_bank (
    .clk(clk), .rst_n(rst_n), .we_i(wr_en), .sel_i(sel_q), .data_i(sh_q),
    .wiper_a_o(wiper_a_o), .wiper_b_o(wiper_b_o));

  assign rd_byte    = sel_q ? wiper_b_o : wiper_a_o;
  assign sda_pull_o = pull_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      sel_q    <= 1'b0;
      sel_nx_q <= 1'b0;
      mack_q   <= 1'b0;
      pull_q   <= 1'b0;
    end else if (start_det) begin
      st_q   <= S_ADDR;
      cnt_q  <= '0;
      pull_q <= 1'b0;
    end else if (stop_det) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      pull_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_ADDR, S_INSTR, S_DATA: begin
          if (scl_rise && cnt_q < FULL) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            cnt_q <= '0;
            if (st_q == S_ADDR) begin
              rw_q <= sh_q[0];
              if (addr_hit) begin
                st_q   <= S_ADDR_ACK;
                pull_q <= 1'b1;
              end else begin
                st_q <= S_IDLE;
              end
            end else if (st_q == S_INSTR) begin
              sel_nx_q <= sh_q[SEL_BIT];
              st_q     <= S_INSTR_ACK;
              pull_q   <= 1'b1;
            end else begin
              st_q   <= S_DATA_ACK;
              pull_q <= 1'b1;
            end
          end
        end
        S_ADDR_ACK: if (scl_fall) begin
          if (rw_q) begin
            tx_q   <= rd_byte;
            pull_q <= ~rd_byte[BYTE_W-1];
            st_q   <= S_TX;
          end else begin
            pull_q <= 1'b0;
            st_q   <= S_INSTR;
          end
        end
        S_INSTR_ACK: if (scl_fall) begin
          pull_q <= 1'b0;
          sel_q  <= sel_nx_q;
          st_q   <= S_DATA;
        end
        S_DATA_ACK: if (scl_fall) begin
          pull_q <= 1'b0;
          st_q   <= S_IDLE;
        end
        S_TX: if (scl_fall) begin
          if (cnt_q == LAST) begin
            cnt_q  <= '0;
            pull_q <= 1'b0;
            st_q   <= S_TX_ACK;
          end else begin
            tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
            pull_q <= ~tx_q[BYTE_W-2];
            cnt_q  <= cnt_q + 1'b1;
          end
        end
        S_TX_ACK: begin
          if (scl_rise) mack_q <= ~sda_lvl;
          else if (scl_fall) begin
            if (mack_q) begin
              tx_q   <= rd_byte;
              pull_q <= ~rd_byte[BYTE_W-1];
              st_q   <= S_TX;
            end else begin
              st_q <= S_IDLE;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R2: idle never touches the line; a START always frees it
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) |-> !sda_pull_o);
  p_start_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st_q == S_ADDR) && !sda_pull_o);
  // R3: a foreign address is never acknowledged
  p_nomatch_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ADDR && scl_fall && cnt_q == FULL && !addr_hit && !start_det && !stop_det)
      |=> !sda_pull_o);
  // R5: the drive only moves while SCL is low, except for a bus condition
  p_pull_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> (!scl_lvl || $past(start_det || stop_det)));
  // R9: wipers move only when a data acknowledge clock ends
  p_wiper_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_q == S_DATA_ACK && scl_fall) |=> $stable(wiper_a_o) && $stable(wiper_b_o));
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
endmodule

// File: tb/test_dual_wiper_i2c.sv
module test_dual_wiper_i2c;
  localparam int H = 10;
  localparam int Q = 5;
  localparam logic [6:0] AF = 7'h2F;
  localparam logic [6:0] AS = 7'h2D;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic m_low = 1'b0;
  logic pull_f, pull_s;
  logic [7:0] wa_f, wb_f, wa_s, wb_s;
  wire sda_bus = ~(m_low | pull_f | pull_s);

  dual_wiper_i2c #(.ADDR_MODE(0)) i_dual_wiper_i2c (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_pin_i(2'b00), .sda_pull_o(pull_f), .wiper_a_o(wa_f), .wiper_b_o(wb_f));

  dual_wiper_i2c #(.ADDR_MODE(1), .RESET_B(8'h40)) i_dual_wiper_i2c_pin (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_pin_i(2'b01), .sda_pull_o(pull_s), .wiper_a_o(wa_s), .wiper_b_o(wb_s));

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit cmp_en = 0;
  logic [7:0] ea_f = 8'h80, eb_f = 8'h80, ea_s = 8'h80, eb_s = 8'h40;
  bit sel_f = 0, sel_s = 0;
  bit ack_f, ack_s;

  task automatic check(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model compared on every clock while SCL is high
  always @(negedge clk) if (cmp_en && rst_n && scl_m) begin
    check("R6 wiper A fixed", wa_f, ea_f);
    check("R6 wiper B fixed", wb_f, eb_f);
    check("R4 wiper A pin",   wa_s, ea_s);
    check("R4 wiper B pin",   wb_s, eb_s);
  end

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    wt(Q); m_low = 1'b0; wt(H); scl_m = 1'b1; wt(H); m_low = 1'b1; wt(H); scl_m = 1'b0;
  endtask
  task automatic bus_stop;
    wt(Q); m_low = 1'b1; wt(H); scl_m = 1'b1; wt(H); m_low = 1'b0; wt(H);
  endtask
  task automatic wbit(bit b);
    wt(Q); m_low = ~b; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0;
  endtask
  task automatic rbit(output bit b, output bit pf, output bit ps);
    wt(Q); m_low = 1'b0; wt(H); scl_m = 1'b1; wt(H/2);
    b = sda_bus; pf = pull_f; ps = pull_s;
    wt(H - H/2); scl_m = 1'b0;
  endtask
  task automatic send(logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b, ack_f, ack_s);
  endtask
  task automatic recv(output logic [7:0] v, input bit mack);
    bit pf, ps;
    for (int i = 7; i >= 0; i--) rbit(v[i], pf, ps);
    wbit(!mack);
  endtask

  task automatic wr(logic [6:0] a, logic [7:0] ins, logic [7:0] d);
    bit hf, hs;
    hf = (a == AF); hs = (a == AS);
    bus_start;
    send({a, 1'b0});
    check("R3 address ack fixed", ack_f, hf);
    check("R4 address ack pin", ack_s, hs);
    if (hf || hs) begin
      send(ins);
      check("R5 instruction ack", ack_f | ack_s, 1);
      if (hf) sel_f = ins[7];
      if (hs) sel_s = ins[7];
      send(d);
      check("R5 data ack", ack_f | ack_s, 1);
      if (hf) begin if (ins[7]) eb_f = d; else ea_f = d; end
      if (hs) begin if (ins[7]) eb_s = d; else ea_s = d; end
      wt(Q);
      check("R5 release after ack", pull_f | pull_s, 0);
    end
    bus_stop;
  endtask

  task automatic rd(logic [6:0] a, string req);
    logic [7:0] v, ex;
    ex = (a == AF) ? (sel_f ? eb_f : ea_f) : (sel_s ? eb_s : ea_s);
    bus_start;
    send({a, 1'b1});
    check("R7 read address ack", ack_f | ack_s, 1);
    recv(v, 1'b1);
    check(req, v, ex);
    recv(v, 1'b0);
    check("R7 second byte after ack", v, ex);
    wt(Q);
    check("R7 released after no-ack", pull_f | pull_s, 0);
    bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    wt(5); rst_n = 1'b1; wt(4);
    check("R1 reset wiper A", wa_f, 8'h80);
    check("R1 reset wiper B", wb_f, 8'h80);
    check("R1 reset pull", pull_f | pull_s, 0);
    cmp_en = 1;

    // R2: bits clocked with no START are ignored
    scl_m = 1'b0; wt(H);
    send({AF, 1'b0});
    check("R2 no ack before START", ack_f, 0);
    bus_stop;
    send({AF, 1'b0});
    check("R2 no ack after STOP", ack_f, 0);
    bus_stop;

    // R8: selection after reset is wiper A (pin device has A=80, B=40)
    rd(AS, "R8 reset selection reads wiper A");

    wr(AF, 8'h00, 8'h35);
    check("R6 wiper A loaded", wa_f, 8'h35);
    wr(AF, 8'h80, 8'hC4);
    check("R6 wiper B loaded", wb_f, 8'hC4);
    rd(AF, "R8 read returns wiper B");
    wr(AF, 8'h7F, 8'h5A);
    check("R6 low instruction bits ignored", wa_f, 8'h5A);
    rd(AF, "R8 read returns wiper A");

    wr(7'h28, 8'h00, 8'h11);
    check("R3 foreign address leaves A", wa_f, 8'h5A);
    wr(AS, 8'h80, 8'h9C);
    check("R4 pin device wiper B", wb_s, 8'h9C);
    check("R4 fixed device untouched", wb_f, 8'hC4);

    // R9: STOP inside the data byte
    bus_start; send({AF, 1'b0}); send(8'h00); sel_f = 1'b0;
    for (int i = 0; i < 4; i++) wbit(1'b1);
    bus_stop;
    check("R9 STOP mid-byte keeps A", wa_f, 8'h5A);

    // R9 + R10: START inside the data byte, then read
    bus_start; send({AF, 1'b0}); send(8'h80); sel_f = 1'b1;
    for (int i = 0; i < 3; i++) wbit(1'b0);
    bus_start;
    send({AF, 1'b1});
    check("R10 address after repeated START", ack_f, 1);
    recv(v, 1'b0);
    check("R9 START mid-byte keeps B", v, 8'hC4);
    bus_stop;

    // R10: repeated START right after an instruction byte
    bus_start; send({AF, 1'b0}); send(8'h80);
    bus_start; send({AF, 1'b0}); send(8'h00); sel_f = 1'b0;
    send(8'h77); ea_f = 8'h77;
    bus_stop;
    check("R10 write after repeated START", wa_f, 8'h77);
    check("R10 wiper B kept", wb_f, 8'hC4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule